// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Port

This block is an 8-bit synchronous serial port. It works as an SPI master or as an SPI slave. One 8-bit control register sets the enable, the idle level of the serial clock and a 4-bit mode code. The same register holds two sticky error flags. The port has a shift register and a separate receive buffer. Software writes a byte to start or preload a transfer. It reads the received byte back from the buffer and then acknowledges it with a read strobe.

As a master, the port makes SCK from the system clock. It divides by a fixed ratio, by a ratio taken from an 8-bit divisor register, or it toggles SCK once per tick from an external timer. As a slave, it takes SCK, SDI and the select input through a two-stage synchronizer, and it can be told to ignore the select input. Data moves MSB first. The first bit is on SDO before the first SCK edge. SDI is sampled on the leading edge (idle to active) and the register shifts on the trailing edge.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0, `sck_oe` and `sdo_oe` are 0, and `buf_full` and `xfer_done` are 0.
- R2: With control bit 5 (enable) at 0, or with a mode code outside {0000, 0001, 0010, 0011, 0100, 0101, 1010}, `sck_oe` and `sdo_oe` stay 0 and buffer writes start nothing.
- R3: A byte goes out MSB first, and its bit 7 is on `sdo_o` from the moment it is loaded. SDI is sampled on each leading SCK edge, so the received byte holds the first sampled bit in bit 7.
- R4: In master mode each SCK half period lasts H system clocks: H = 2 for mode 0000, 8 for 0001, 32 for 0010, and 2*(D+1) for 1010, where D is the divisor register. `xfer_done` and `buf_full` go high exactly 16*H clock edges after the edge that takes the buffer write.
- R5: In mode 0011 each clock with `tmr_tick` high toggles SCK during a transfer. The byte completes on the 16th tick.
- R6: Control bit 4 sets the SCK idle level (1 = high, 0 = low). SCK is back at that level once a master byte completes.
- R7: Every completed byte gives `xfer_done` high for exactly one cycle with `buf_full` high. A `buf_re` strobe clears `buf_full`.
- R8: Control bit 7 is set when the buffer is written while a byte is in progress, and that write is dropped. A control write with bit 7 at 1 leaves the flag unchanged, and a write with bit 7 at 0 clears it.
- R9: Control bit 6 is set when a slave byte completes while `buf_full` is still 1. The buffer then keeps its old byte. In master mode a new byte always replaces the buffer and bit 6 never sets. A control write with bit 6 at 0 clears it.
- R10: In mode 0100, a high `ss_n_i` releases SDO (`sdo_oe` = 0), ignores SCK edges and clears the bit count, so a partly shifted byte is dropped.
- R11: In mode 0101 the slave shifts and drives SDO whatever the level of `ss_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data {wcol, ovf, en, ckp, mode[3:0]} |
| ctl_rdata | output | 8 | Control register contents |
| div_we | input | 1 | Divisor register write strobe |
| div_wdata | input | 8 | Divisor value D for mode 1010 (D = 0 unsupported) |
| buf_we | input | 1 | Transmit byte write strobe |
| buf_wdata | input | 8 | Byte to send |
| buf_re | input | 1 | Acknowledges the received byte |
| buf_rdata | output | 8 | Received byte |
| buf_full | output | 1 | Received byte waiting |
| xfer_done | output | 1 | One-cycle pulse per completed byte |
| tmr_tick | input | 1 | External timer tick for mode 0011 |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | SCK output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | SDO output enable |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
In master mode the bench counts edges from the edge that takes the buffer write. It samples one cycle before and one cycle after edge 16*H, and expects `xfer_done` and `buf_full` high only at the later point. In timer mode it checks after the 15th and after the 16th tick. Slave inputs pass through a two-stage synchronizer and an edge register, so a slave result appears about three clocks after an SCK change. The bench holds each SCK level for four clocks and waits six clocks after the last edge before it samples.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BYTE_W = 8;

  localparam logic [3:0] MD_FOSC4    = 4'b0000;
  localparam logic [3:0] MD_FOSC16   = 4'b0001;
  localparam logic [3:0] MD_FOSC64   = 4'b0010;
  localparam logic [3:0] MD_TIMER    = 4'b0011;
  localparam logic [3:0] MD_SLV_SEL  = 4'b0100;
  localparam logic [3:0] MD_SLV_FREE = 4'b0101;
  localparam logic [3:0] MD_DIVREG   = 4'b1010;

  typedef struct packed {
    logic       wcol;
    logic       ovf;
    logic       en;
    logic       ckp;
    logic [3:0] mode;
  } ctl_t;

  function automatic logic mode_master(input logic [3:0] m);
    return (m == MD_FOSC4) || (m == MD_FOSC16) || (m == MD_FOSC64) ||
           (m == MD_TIMER) || (m == MD_DIVREG);
  endfunction

  function automatic logic mode_slave(input logic [3:0] m);
    return (m == MD_SLV_SEL) || (m == MD_SLV_FREE);
  endfunction
endpackage

// File: rtl/spi_port_rate.sv
module spi_port_rate
  import spi_port_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [3:0]       mode,
  input  logic [DIV_W-1:0] div,
  input  logic             tmr_tick,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt_q, cnt_d, half;
  logic             hit;

  always_comb begin
    case (mode)
      MD_FOSC16: half = CNT_W'(8);
      MD_FOSC64: half = CNT_W'(32);
      MD_DIVREG: half = CNT_W'({div, 1'b0}) + CNT_W'(2);
      default:   half = CNT_W'(2);
    endcase
  end

  assign hit  = (cnt_q == half - CNT_W'(1));
  assign tick = run && ((mode == MD_TIMER) ? tmr_tick : hit);

  always_comb begin
    if (!run || hit) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              div_we,
  input  logic [DIV_W-1:0]  div_wdata,
  input  logic              buf_we,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              buf_re,
  output logic [DATA_W-1:0] buf_rdata,
  output logic              buf_full,
  output logic              xfer_done,
  input  logic              tmr_tick,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic              ss_n_i
);
  localparam int BCNT_W = $clog2(DATA_W);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  ctl_t              ctl_q, ctl_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [DATA_W-1:0] sr_q, sr_d, rbuf_q, rbuf_d, shifted;
  logic              full_q, full_d, done_q, done_d, busy_q, busy_d;
  logic              phase_q, phase_d, rxb_q, rxb_d, sck_prev_q;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;

  // slave-side synchronized inputs
  logic [2:0] sync_q;
  logic       sck_s, sdi_s, ss_s;
  spi_port_sync #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_i_n),
    .d    ({ss_n_i, sdi_i, sck_i}),
    .q    (sync_q)
  );
  assign sck_s = sync_q[0];
  assign sdi_s = sync_q[1];
  assign ss_s  = sync_q[2];

  logic is_m, is_s, ss_act, active, busy_any, tick;
  logic s_rise, s_fall, lead_ev, trail_ev, last_ev, wr_ok, wr_col, ovf_set;

  assign is_m     = ctl_q.en && mode_master(ctl_q.mode);
  assign is_s     = ctl_q.en && mode_slave(ctl_q.mode);
  assign ss_act   = (ctl_q.mode != MD_SLV_SEL) || !ss_s;
  assign active   = is_m || (is_s && ss_act);
  assign busy_any = is_m ? busy_q : (phase_q || (bcnt_q != '0));

  spi_port_rate #(.DIV_W(DIV_W)) u_rate (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (is_m && busy_q),
    .mode    (ctl_q.mode),
    .div     (div_q),
    .tmr_tick(tmr_tick),
    .tick    (tick)
  );

  // leading edge = idle -> active level of SCK
  assign s_rise   = ((sck_s ^ ctl_q.ckp) == 1'b1) && ((sck_prev_q ^ ctl_q.ckp) == 1'b0);
  assign s_fall   = ((sck_s ^ ctl_q.ckp) == 1'b0) && ((sck_prev_q ^ ctl_q.ckp) == 1'b1);
  assign lead_ev  = is_m ? (busy_q && tick && !phase_q) : (is_s && ss_act && s_rise);
  assign trail_ev = is_m ? (busy_q && tick && phase_q)  : (is_s && ss_act && s_fall && phase_q);
  assign last_ev  = trail_ev && (bcnt_q == BCNT_W'(DATA_W - 1));
  assign wr_ok    = buf_we && (is_m || is_s) && !busy_any;
  assign wr_col   = buf_we && (is_m || is_s) && busy_any;
  assign ovf_set  = last_ev && is_s && full_q;
  assign shifted  = {sr_q[DATA_W-2:0], rxb_q};

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d      = ctl_t'(ctl_wdata);
      ctl_d.wcol = ctl_q.wcol & ctl_wdata[7];
      ctl_d.ovf  = ctl_q.ovf & ctl_wdata[6];
    end
    if (wr_col)  ctl_d.wcol = 1'b1;
    if (ovf_set) ctl_d.ovf  = 1'b1;
    div_d = div_we ? div_wdata : div_q;
  end

  always_comb begin
    sr_d    = sr_q;
    rbuf_d  = rbuf_q;
    full_d  = full_q;
    busy_d  = busy_q;
    phase_d = phase_q;
    bcnt_d  = bcnt_q;
    rxb_d   = rxb_q;
    done_d  = 1'b0;
    if (buf_re) full_d = 1'b0;
    if (!active) begin
      busy_d  = 1'b0;
      phase_d = 1'b0;
      bcnt_d  = '0;
    end
    if (wr_ok) begin
      sr_d    = buf_wdata;
      busy_d  = is_m;
      phase_d = 1'b0;
      bcnt_d  = '0;
    end
    if (lead_ev) begin
      rxb_d   = is_m ? sdi_i : sdi_s;
      phase_d = 1'b1;
    end
    if (trail_ev) begin
      sr_d    = shifted;
      phase_d = 1'b0;
      bcnt_d  = bcnt_q + BCNT_W'(1);
      if (last_ev) begin
        bcnt_d = '0;
        busy_d = 1'b0;
        done_d = 1'b1;
        if (!ovf_set) begin
          rbuf_d = shifted;
          full_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctl_q      <= '0;
      div_q      <= '0;
      sr_q       <= '0;
      rbuf_q     <= '0;
      full_q     <= 1'b0;
      done_q     <= 1'b0;
      busy_q     <= 1'b0;
      phase_q    <= 1'b0;
      bcnt_q     <= '0;
      rxb_q      <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      ctl_q      <= ctl_d;
      div_q      <= div_d;
      sr_q       <= sr_d;
      rbuf_q     <= rbuf_d;
      full_q     <= full_d;
      done_q     <= done_d;
      busy_q     <= busy_d;
      phase_q    <= phase_d;
      bcnt_q     <= bcnt_d;
      rxb_q      <= rxb_d;
      sck_prev_q <= sck_s;
    end
  end

  assign ctl_rdata = ctl_q;
  assign buf_rdata = rbuf_q;
  assign buf_full  = full_q;
  assign xfer_done = done_q;
  assign sck_o     = ctl_q.ckp ^ (is_m && phase_q);
  assign sck_oe    = is_m;
  assign sdo_o     = sr_q[DATA_W-1];
  assign sdo_oe    = active;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_rdata,
  input logic       buf_we,
  input logic       buf_re,
  input logic       buf_full,
  input logic       xfer_done,
  input logic       sck_oe,
  input logic       sdo_oe,
  input logic       ss_n_i
);
  // R2
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[5] |-> (!sck_oe && !sdo_oe));

  // R8
  wcol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rdata[7]) |-> $past(buf_we));

  // R9
  ovf_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rdata[6]) |-> ($past(ctl_rdata[3:1]) == 3'b010));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R7
  done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> buf_full);

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_re |=> (!buf_full || xfer_done));

  // R10
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[5] && (ctl_rdata[3:0] == 4'b0100) && $past(ss_n_i, 2)) |-> !sdo_oe);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_rdata(ctl_rdata),
  .buf_we   (buf_we),
  .buf_re   (buf_re),
  .buf_full (buf_full),
  .xfer_done(xfer_done),
  .sck_oe   (sck_oe),
  .sdo_oe   (sdo_oe),
  .ss_n_i   (ss_n_i)
);

// File: tb/spi_port_tb.sv
module spi_port_tb;
  logic       clk, rst_n;
  logic       ctl_we, div_we, buf_we, buf_re, tmr_tick;
  logic [7:0] ctl_wdata, div_wdata, buf_wdata;
  logic [7:0] ctl_rdata, buf_rdata;
  logic       buf_full, xfer_done, sck_i, sck_o, sck_oe, sdi_i, sdo_o, sdo_oe, ss_n_i;
  logic       lb, sdi_drv, ckp_b, sck_prev_b;
  logic [7:0] wire_q;
  int         checks, errors;

  spi_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .div_we(div_we), .div_wdata(div_wdata),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_re(buf_re), .buf_rdata(buf_rdata),
    .buf_full(buf_full), .xfer_done(xfer_done), .tmr_tick(tmr_tick),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .ss_n_i(ss_n_i)
  );

  assign sdi_i = lb ? ~sdo_o : sdi_drv;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // master wire monitor: SDO at each leading SCK edge
  always @(negedge clk) begin
    if (sck_oe && (sck_o != sck_prev_b) && (sck_o == ~ckp_b))
      wire_q <= {wire_q[6:0], sdo_o};
    sck_prev_b <= sck_o;
  end

  // {ctl, divisor, tx byte, expected half period}
  localparam logic [31:0] VEC [5] = '{
    {8'h20, 8'h00, 8'hA5, 8'd2},
    {8'h31, 8'h00, 8'h3C, 8'd8},
    {8'h22, 8'h00, 8'h81, 8'd32},
    {8'h2A, 8'h02, 8'h5E, 8'd6},
    {8'h3A, 8'h01, 8'hF0, 8'd4}
  };

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_buf(input logic [7:0] v);
    @(negedge clk); buf_we = 1'b1; buf_wdata = v;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic rd_buf();
    @(negedge clk); buf_re = 1'b1;
    @(negedge clk); buf_re = 1'b0;
  endtask

  task automatic sbits(input logic [7:0] b, input int n, output logic [7:0] seen);
    seen = 8'h00;
    for (int i = 0; i < n; i++) begin
      sdi_drv = b[7-i];
      repeat (4) @(negedge clk);
      seen = {seen[6:0], sdo_o};
      sck_i = 1'b1;
      repeat (4) @(negedge clk);
      sck_i = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] seen;
    checks = 0; errors = 0;
    rst_n = 1'b0; ctl_we = 0; div_we = 0; buf_we = 0; buf_re = 0; tmr_tick = 0;
    ctl_wdata = 0; div_wdata = 0; buf_wdata = 0; sck_i = 0; ss_n_i = 1'b1;
    lb = 1'b1; sdi_drv = 0; ckp_b = 0; sck_prev_b = 0; wire_q = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(ctl_rdata == 8'h00, "R1 ctl", ctl_rdata, 8'h00);
    chk(!sck_oe && !sdo_oe, "R1 oe", {sck_oe, sdo_oe}, 8'h00);
    chk(!buf_full && !xfer_done, "R1 status", {buf_full, xfer_done}, 8'h00);

    // R4 R3 R6 R7 master vector walk
    foreach (VEC[k]) begin
      automatic logic [7:0] c  = VEC[k][31:24];
      automatic logic [7:0] tx = VEC[k][15:8];
      automatic int         h  = int'(VEC[k][7:0]);
      ckp_b = c[4];
      @(negedge clk); div_we = 1'b1; div_wdata = VEC[k][23:16];
      @(negedge clk); div_we = 1'b0;
      wr_ctl(c);
      chk(sck_o == c[4], "R6 idle", {7'd0, sck_o}, {7'd0, c[4]});
      wr_buf(tx);
      repeat (16*h - 1) @(negedge clk);
      chk(!xfer_done && !buf_full, "R4 early", {xfer_done, buf_full}, 8'h00);
      @(negedge clk);
      chk(xfer_done && buf_full, "R4 due", {xfer_done, buf_full}, 8'h03);
      chk(buf_rdata == ~tx, "R3 rx", buf_rdata, ~tx);
      chk(wire_q == tx, "R3 wire", wire_q, tx);
      chk(sck_o == c[4], "R6 back", {7'd0, sck_o}, {7'd0, c[4]});
      @(negedge clk);
      chk(!xfer_done, "R7 pulse", {7'd0, xfer_done}, 8'h00);
      rd_buf();
      chk(!buf_full, "R7 read", {7'd0, buf_full}, 8'h00);
    end

    // R9 master never overflows
    ckp_b = 1'b0;
    wr_ctl(8'h20);
    wr_buf(8'h11); repeat (40) @(negedge clk);
    wr_buf(8'h22); repeat (40) @(negedge clk);
    chk(ctl_rdata[6] == 1'b0, "R9 master", ctl_rdata, 8'h20);
    chk(buf_rdata == 8'hDD, "R9 master data", buf_rdata, 8'hDD);
    rd_buf();

    // R8 write collision
    wr_buf(8'h33); repeat (5) @(negedge clk);
    wr_buf(8'h44);
    chk(ctl_rdata[7] == 1'b1, "R8 set", ctl_rdata, 8'hA0);
    repeat (40) @(negedge clk);
    chk(buf_rdata == 8'hCC, "R8 dropped", buf_rdata, 8'hCC);
    wr_ctl(8'hA0);
    chk(ctl_rdata == 8'hA0, "R8 keep", ctl_rdata, 8'hA0);
    wr_ctl(8'h20);
    chk(ctl_rdata == 8'h20, "R8 clear", ctl_rdata, 8'h20);
    rd_buf();

    // R5 timer mode
    wr_ctl(8'h23);
    wr_buf(8'h6B);
    for (int t = 0; t < 15; t++) begin
      @(negedge clk); tmr_tick = 1'b1;
      @(negedge clk); tmr_tick = 1'b0;
      @(negedge clk);
    end
    chk(!buf_full, "R5 15 ticks", {7'd0, buf_full}, 8'h00);
    @(negedge clk); tmr_tick = 1'b1;
    @(negedge clk); tmr_tick = 1'b0;
    chk(buf_full && buf_rdata == 8'h94, "R5 16 ticks", buf_rdata, 8'h94);
    rd_buf();

    // R2 disabled and reserved
    wr_ctl(8'h00);
    chk(!sck_oe && !sdo_oe, "R2 disabled", {sck_oe, sdo_oe}, 8'h00);
    wr_buf(8'h55); repeat (40) @(negedge clk);
    chk(!buf_full, "R2 disabled write", {7'd0, buf_full}, 8'h00);
    wr_ctl(8'h27);
    chk(!sck_oe && !sdo_oe, "R2 reserved", {sck_oe, sdo_oe}, 8'h00);
    wr_buf(8'h55); repeat (40) @(negedge clk);
    chk(!buf_full && !ctl_rdata[7], "R2 reserved write", ctl_rdata, 8'h27);

    // R3 R10 slave, select honoured
    lb = 1'b0; ss_n_i = 1'b0;
    wr_ctl(8'h24);
    repeat (4) @(negedge clk);
    wr_buf(8'hC3);
    sbits(8'h96, 8, seen);
    chk(buf_full && buf_rdata == 8'h96, "R3 slave rx", buf_rdata, 8'h96);
    chk(seen == 8'hC3, "R3 slave tx", seen, 8'hC3);

    // R9 slave overflow
    sbits(8'h11, 8, seen);
    chk(ctl_rdata[6] == 1'b1, "R9 set", ctl_rdata, 8'h64);
    chk(buf_rdata == 8'h96, "R9 keep", buf_rdata, 8'h96);
    wr_ctl(8'h24);
    chk(ctl_rdata == 8'h24, "R9 clear", ctl_rdata, 8'h24);
    rd_buf();

    // R10 partial byte dropped
    sbits(8'hF0, 4, seen);
    ss_n_i = 1'b1; repeat (6) @(negedge clk);
    chk(!sdo_oe, "R10 release", {7'd0, sdo_oe}, 8'h00);
    ss_n_i = 1'b0; repeat (6) @(negedge clk);
    sbits(8'h5A, 8, seen);
    chk(buf_full && buf_rdata == 8'h5A, "R10 resync", buf_rdata, 8'h5A);
    rd_buf();
    ss_n_i = 1'b1; repeat (6) @(negedge clk);
    sbits(8'h77, 8, seen);
    chk(!buf_full, "R10 ignore", {7'd0, buf_full}, 8'h00);

    // R11 select ignored
    wr_ctl(8'h25);
    repeat (2) @(negedge clk);
    chk(sdo_oe, "R11 drive", {7'd0, sdo_oe}, 8'h01);
    sbits(8'h3E, 8, seen);
    chk(buf_full && buf_rdata == 8'h3E, "R11 rx", buf_rdata, 8'h3E);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule